// File: doc/BRIEF.md
# Programmable Flag Offset Loader

This block holds the almost-full and almost-empty offset values for a pair of FIFOs: one offset pair per FIFO, four registers in all. The programming method is fixed at the end of master reset, when three select pins are captured. Those pins are the high select pin, the serial-enable/select-1 pin and the serial-data/select-0 pin. The captured code picks one of three methods. A preset fills all four registers with one of five constants. A parallel load takes four successive words from a data port. A serial load shifts one bit per clock into a single chain that runs through all four registers.

The FIFO flag comparators read the four offsets. They also read the done output, which reports that programming is complete. A partial reset input pauses loading and keeps both the method and the offsets. The block is sampled on one clock. The master reset is synchronous and active low.

Top module: `flag_ofs_loader`

## Requirements
- R1: The select code {cfg_sel2, sen_n_sel1, sdat_sel0} is captured on every rising clock edge that samples mrst_n low. The value from the last such edge fixes the method until the next master reset, whatever the select pins do after that. Code 000 selects parallel load. Codes 110 and 111 select serial load. Codes 001 to 101 select a preset.
- R2: Preset codes map to values as follows: 001 gives 8, 010 gives 16, 011 gives 64, 100 gives 256 and 101 gives 1024. The chosen value appears on all four offsets. done is high from the first rising edge that samples mrst_n high.
- R3: In parallel mode, each rising edge with wr_en high loads wr_data[13:0] into the next register. The order is af_ofs0, ae_ofs0, af_ofs1, ae_ofs1. wr_data[35:14] is ignored.
- R4: In serial mode, each rising edge with sen_n_sel1 low shifts sdat_sel0 into the chain {af_ofs0, ae_ofs0, af_ofs1, ae_ofs1} at ae_ofs1 bit 0. The chain moves toward af_ofs0 bit 13. The first bit therefore ends in af_ofs0 bit 13 and the last bit in ae_ofs1 bit 0.
- R5: In serial mode, an edge with sen_n_sel1 high shifts nothing.
- R6: done rises after the 56th accepted bit in serial mode, or after the 4th accepted word in parallel mode, and not before.
- R7: Once done is high, further writes and shifts are ignored and done stays high until the next master reset.
- R8: While prst_n is low, writes and shifts are ignored. The offsets and the method are kept.
- R9: Master reset clears the parallel and serial offsets to zero, drives done low and restarts the bit or word count. Serial-enable edges during master reset shift nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Write-side clock |
| mrst_n | input | 1 | Master reset, synchronous, active low |
| prst_n | input | 1 | Partial reset, active low; pauses loading |
| cfg_sel2 | input | 1 | Select bit 2 |
| sen_n_sel1 | input | 1 | Select bit 1 during reset; serial enable, active low, afterwards |
| sdat_sel0 | input | 1 | Select bit 0 during reset; serial data afterwards |
| wr_en | input | 1 | Parallel word write strobe |
| wr_data | input | 36 | Parallel word; low 14 bits used |
| af_ofs0 | output | 14 | Almost-full offset, FIFO 0 |
| ae_ofs0 | output | 14 | Almost-empty offset, FIFO 0 |
| af_ofs1 | output | 14 | Almost-full offset, FIFO 1 |
| ae_ofs1 | output | 14 | Almost-empty offset, FIFO 1 |
| done | output | 1 | Programming complete |

## Verification
The assertions check on every cycle that:
- the captured method holds still after reset;
- the bit and word counters never pass their limits;
- each accepted shift advances the count by one;
- done never falls outside reset;
- the offsets freeze once done is high or while partial reset is low.

Only the bench's scenarios can show the rest. This covers the preset value for each code, the order in which words and bits land in the four registers, and that ignored upper data bits and serial-enable-high cycles leave the chain alone. It also covers done rising on exactly the 56th bit or 4th word.

// File: rtl/flo_pkg.sv
package flo_pkg;

   typedef enum logic [1:0] {
      LD_PRESET   = 2'd0,
      LD_PARALLEL = 2'd1,
      LD_SERIAL   = 2'd2
   } ld_mode_e;

   localparam int SLOTS = 4;

   function automatic ld_mode_e decode_mode(input logic [2:0] code);
      case (code)
         3'b000:          return LD_PARALLEL;
         3'b110, 3'b111:  return LD_SERIAL;
         default:         return LD_PRESET;
      endcase
   endfunction

   // preset offsets are powers of two; return the exponent
   function automatic int unsigned preset_exp(input logic [2:0] code);
      case (code)
         3'b001:  return 3;
         3'b010:  return 4;
         3'b011:  return 6;
         3'b100:  return 8;
         3'b101:  return 10;
         default: return 0;
      endcase
   endfunction

endpackage

// File: rtl/flo_mode_latch.sv
module flo_mode_latch
   import flo_pkg::*;
#(
   parameter int OFS_W = 14
) (
   input  logic             clk,
   input  logic             mrst_n,
   input  logic [2:0]       sel,
   output ld_mode_e         mode,
   output logic [OFS_W-1:0] preset_val,
   output logic             run
);

   ld_mode_e         mode_q;
   logic [OFS_W-1:0] pv_q;
   logic             run_q;

   always_ff @(posedge clk) begin
      if (!mrst_n) begin
         mode_q <= decode_mode(sel);
         pv_q   <= OFS_W'(1) << preset_exp(sel);
         run_q  <= 1'b0;
      end else begin
         run_q  <= 1'b1;
      end
   end

   assign mode       = mode_q;
   assign preset_val = pv_q;
   assign run        = run_q;

   // R1
   mode_hold_chk: assert property (@(posedge clk) disable iff (!mrst_n)
      mrst_n |=> $stable(mode_q));

endmodule

// File: rtl/flo_serial_chain.sv
module flo_serial_chain #(
   parameter int OFS_W = 14,
   parameter int SLOTS = 4
) (
   input  logic                   clk,
   input  logic                   mrst_n,
   input  logic                   enable,
   input  logic                   sen_n,
   input  logic                   sdat,
   output logic [SLOTS*OFS_W-1:0] chain,
   output logic                   full
);

   localparam int NBITS = SLOTS * OFS_W;
   localparam int CW    = $clog2(NBITS + 1);

   logic [NBITS-1:0] sh_q;
   logic [CW-1:0]    cnt_q;
   logic             go;

   assign full = (cnt_q == CW'(NBITS));
   assign go   = enable && !sen_n && !full;

   always_ff @(posedge clk) begin
      if (!mrst_n) begin
         sh_q  <= '0;
         cnt_q <= '0;
      end else if (go) begin
         sh_q  <= {sh_q[NBITS-2:0], sdat};
         cnt_q <= cnt_q + CW'(1);
      end
   end

   assign chain = sh_q;

   // R6
   ser_cnt_bound_chk: assert property (@(posedge clk) disable iff (!mrst_n)
      cnt_q <= CW'(NBITS));

   // R4
   ser_step_chk: assert property (@(posedge clk) disable iff (!mrst_n)
      go |=> (cnt_q == CW'($past(cnt_q) + CW'(1))));

endmodule

// File: rtl/flo_word_bank.sv
module flo_word_bank #(
   parameter int OFS_W  = 14,
   parameter int DATA_W = 36,
   parameter int SLOTS  = 4
) (
   input  logic                   clk,
   input  logic                   mrst_n,
   input  logic                   enable,
   input  logic                   wr_en,
   input  logic [DATA_W-1:0]      wr_data,
   output logic [SLOTS*OFS_W-1:0] words,
   output logic                   full
);

   localparam int SW = $clog2(SLOTS + 1);

   logic [SW-1:0] slot_q;
   logic          go;
   logic          unused_hi;

   assign unused_hi = ^wr_data[DATA_W-1:OFS_W];
   assign full      = (slot_q == SW'(SLOTS));
   assign go        = enable && wr_en && !full;

   always_ff @(posedge clk) begin
      if (!mrst_n)  slot_q <= '0;
      else if (go)  slot_q <= slot_q + SW'(1);
   end

   for (genvar g = 0; g < SLOTS; g++) begin : g_slot
      logic [OFS_W-1:0] w_q;
      always_ff @(posedge clk) begin
         if (!mrst_n)                         w_q <= '0;
         else if (go && (slot_q == SW'(g)))   w_q <= wr_data[OFS_W-1:0];
      end
      assign words[(SLOTS-g)*OFS_W-1 -: OFS_W] = w_q;
   end

   // R6
   slot_bound_chk: assert property (@(posedge clk) disable iff (!mrst_n)
      slot_q <= SW'(SLOTS));

endmodule

// File: rtl/flag_ofs_loader.sv
module flag_ofs_loader
   import flo_pkg::*;
#(
   parameter int OFS_W  = 14,
   parameter int DATA_W = 36
) (
   input  logic              clk,
   input  logic              mrst_n,
   input  logic              prst_n,
   input  logic              cfg_sel2,
   input  logic              sen_n_sel1,
   input  logic              sdat_sel0,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   output logic [OFS_W-1:0]  af_ofs0,
   output logic [OFS_W-1:0]  ae_ofs0,
   output logic [OFS_W-1:0]  af_ofs1,
   output logic [OFS_W-1:0]  ae_ofs1,
   output logic              done
);

   localparam int CHAIN_W = SLOTS * OFS_W;

   if (OFS_W < 11) begin : g_bad_ofs
      $error("OFS_W must hold the largest preset (1024)");
   end
   if (OFS_W >= DATA_W) begin : g_bad_data
      $error("DATA_W must be wider than OFS_W");
   end

   ld_mode_e             mode;
   logic [OFS_W-1:0]     preset_val;
   logic                 run;
   logic [CHAIN_W-1:0]   ser_chain;
   logic [CHAIN_W-1:0]   par_chain;
   logic [CHAIN_W-1:0]   out_chain;
   logic                 ser_full;
   logic                 par_full;

   flo_mode_latch #(.OFS_W(OFS_W)) u_mode (
      .clk        (clk),
      .mrst_n     (mrst_n),
      .sel        ({cfg_sel2, sen_n_sel1, sdat_sel0}),
      .mode       (mode),
      .preset_val (preset_val),
      .run        (run)
   );

   flo_serial_chain #(.OFS_W(OFS_W), .SLOTS(SLOTS)) u_ser (
      .clk    (clk),
      .mrst_n (mrst_n),
      .enable ((mode == LD_SERIAL) && prst_n),
      .sen_n  (sen_n_sel1),
      .sdat   (sdat_sel0),
      .chain  (ser_chain),
      .full   (ser_full)
   );

   flo_word_bank #(.OFS_W(OFS_W), .DATA_W(DATA_W), .SLOTS(SLOTS)) u_par (
      .clk     (clk),
      .mrst_n  (mrst_n),
      .enable  ((mode == LD_PARALLEL) && prst_n),
      .wr_en   (wr_en),
      .wr_data (wr_data),
      .words   (par_chain),
      .full    (par_full)
   );

   always_comb begin
      case (mode)
         LD_SERIAL: begin
            out_chain = ser_chain;
            done      = ser_full;
         end
         LD_PARALLEL: begin
            out_chain = par_chain;
            done      = par_full;
         end
         default: begin
            out_chain = {SLOTS{preset_val}};
            done      = run;
         end
      endcase
   end

   assign af_ofs0 = out_chain[4*OFS_W-1 -: OFS_W];
   assign ae_ofs0 = out_chain[3*OFS_W-1 -: OFS_W];
   assign af_ofs1 = out_chain[2*OFS_W-1 -: OFS_W];
   assign ae_ofs1 = out_chain[1*OFS_W-1 -: OFS_W];

   // R7
   done_sticky_chk: assert property (@(posedge clk) disable iff (!mrst_n)
      done |=> done);

   // R7
   frozen_after_done_chk: assert property (@(posedge clk) disable iff (!mrst_n)
      done |=> $stable({af_ofs0, ae_ofs0, af_ofs1, ae_ofs1}));

   // R8
   prst_hold_chk: assert property (@(posedge clk) disable iff (!mrst_n)
      !prst_n |=> $stable({af_ofs0, ae_ofs0, af_ofs1, ae_ofs1}));

   // R9
   reset_clears_done_chk: assert property (@(posedge clk)
      !mrst_n |=> !done);

endmodule

// File: tb/flag_ofs_loader_bench.sv
`timescale 1ns/1ps
module flag_ofs_loader_bench;

   localparam int W  = 14;
   localparam int DW = 36;

   logic          clk = 1'b0;
   logic          mrst_n = 1'b0;
   logic          prst_n = 1'b1;
   logic          cfg_sel2 = 1'b0;
   logic          sen_n_sel1 = 1'b0;
   logic          sdat_sel0 = 1'b0;
   logic          wr_en = 1'b0;
   logic [DW-1:0] wr_data = '0;
   logic [W-1:0]  af0, ae0, af1, ae1;
   logic          done;

   int total = 0;
   int bad   = 0;

   always #5 clk = ~clk;

   flag_ofs_loader u_flag_ofs_loader (
      .clk(clk), .mrst_n(mrst_n), .prst_n(prst_n), .cfg_sel2(cfg_sel2),
      .sen_n_sel1(sen_n_sel1), .sdat_sel0(sdat_sel0), .wr_en(wr_en),
      .wr_data(wr_data), .af_ofs0(af0), .ae_ofs0(ae0), .af_ofs1(af1),
      .ae_ofs1(ae1), .done(done)
   );

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic chk_all(input string req, input logic [W-1:0] e0,
                          input logic [W-1:0] e1, input logic [W-1:0] e2,
                          input logic [W-1:0] e3);
      chk(req, "af_ofs0", 32'(af0), 32'(e0));
      chk(req, "ae_ofs0", 32'(ae0), 32'(e1));
      chk(req, "af_ofs1", 32'(af1), 32'(e2));
      chk(req, "ae_ofs1", 32'(ae1), 32'(e3));
   endtask

   task automatic drive_sel(input logic [2:0] s);
      {cfg_sel2, sen_n_sel1, sdat_sel0} = s;
   endtask

   // early code for the first reset edges, last code for the final one
   task automatic do_reset(input logic [2:0] early, input logic [2:0] last);
      @(negedge clk);
      mrst_n = 1'b0; prst_n = 1'b1; wr_en = 1'b0;
      drive_sel(early);
      repeat (2) @(negedge clk);
      drive_sel(last);
      @(negedge clk);
      chk("R9", "done in reset", 32'(done), 32'd0);
      mrst_n = 1'b1;
      drive_sel(3'b010);
      @(negedge clk);
   endtask

   task automatic shift_bit(input logic b);
      sen_n_sel1 = 1'b0; sdat_sel0 = b;
      @(negedge clk);
      sen_n_sel1 = 1'b1;
   endtask

   task automatic write_word(input logic [W-1:0] v);
      wr_en = 1'b1; wr_data = {22'h2A5A5A, v};
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic test_reset_state();
      do_reset(3'b011, 3'b000);
      chk("R9", "done after reset", 32'(done), 32'd0);
      chk_all("R1", '0, '0, '0, '0);
   endtask

   task automatic test_presets();
      logic [W-1:0] exp_v [5] = '{14'd8, 14'd16, 14'd64, 14'd256, 14'd1024};
      for (int i = 0; i < 5; i++) begin
         do_reset(3'b000, 3'(i + 1));
         chk("R2", "done preset", 32'(done), 32'd1);
         chk_all("R2", exp_v[i], exp_v[i], exp_v[i], exp_v[i]);
      end
      for (int k = 0; k < 4; k++) begin
         drive_sel(3'(k * 3));
         @(negedge clk);
      end
      drive_sel(3'b010);
      chk_all("R1", 14'd1024, 14'd1024, 14'd1024, 14'd1024);
   endtask

   task automatic test_parallel();
      do_reset(3'b101, 3'b000);
      write_word(14'h0ABC);
      chk_all("R3", 14'h0ABC, 0, 0, 0);
      write_word(14'h3001);
      chk_all("R3", 14'h0ABC, 14'h3001, 0, 0);
      prst_n = 1'b0; wr_en = 1'b1; wr_data = 36'hF_FFFF_FFFF;
      @(negedge clk);
      prst_n = 1'b1; wr_en = 1'b0;
      chk_all("R8", 14'h0ABC, 14'h3001, 0, 0);
      write_word(14'h1F2E);
      chk("R6", "done after 3 words", 32'(done), 32'd0);
      write_word(14'h2467);
      chk("R6", "done after 4 words", 32'(done), 32'd1);
      chk_all("R3", 14'h0ABC, 14'h3001, 14'h1F2E, 14'h2467);
      write_word(14'h1111);
      chk_all("R7", 14'h0ABC, 14'h3001, 14'h1F2E, 14'h2467);
      chk("R7", "done holds", 32'(done), 32'd1);
   endtask

   task automatic test_serial();
      logic [55:0] v = 56'hA5C31F0E9B2764;
      logic [55:0] snap;
      do_reset(3'b000, 3'b110);
      for (int i = 55; i >= 0; i--) begin
         if (i == 30) begin
            snap = {af0, ae0, af1, ae1};
            sen_n_sel1 = 1'b1; sdat_sel0 = ~v[i];
            @(negedge clk);
            chk("R5", "chain with enable high", 32'(snap[31:0] ^ {af1, ae1}), 32'd0);
            prst_n = 1'b0; sen_n_sel1 = 1'b0; sdat_sel0 = 1'b1;
            @(negedge clk);
            prst_n = 1'b1; sen_n_sel1 = 1'b1;
            chk("R8", "chain in partial reset", 32'(snap[31:0] ^ {af1, ae1}), 32'd0);
         end
         if (i == 0) chk("R6", "done after 55 bits", 32'(done), 32'd0);
         shift_bit(v[i]);
      end
      chk("R6", "done after 56 bits", 32'(done), 32'd1);
      chk_all("R4", v[55:42], v[41:28], v[27:14], v[13:0]);
      for (int k = 0; k < 5; k++) shift_bit(1'b1);
      chk_all("R7", v[55:42], v[41:28], v[27:14], v[13:0]);
   endtask

   task automatic test_serial_alt();
      do_reset(3'b000, 3'b111);
      chk_all("R9", '0, '0, '0, '0);
      shift_bit(1'b1);
      chk("R1", "serial code 111", 32'(ae1), 32'd1);
      chk("R6", "done after 1 bit", 32'(done), 32'd0);
   endtask

   initial begin
      test_reset_state();
      test_presets();
      test_parallel();
      test_serial();
      test_serial_alt();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule